// File: doc/BRIEF.md
# CPU-to-ISA I/O Address Translator

This block sits between a 32-bit CPU bus and an ISA-style I/O port bus. A CPU access is taken only when its address falls in an 8 MB aperture based at 0x80000000. An access outside that aperture is left alone. For an accepted access the bridge turns the CPU address into an I/O port number and hands a single request to the I/O side. It then waits for the I/O side to complete and returns an acknowledge to the CPU.

The port number is built in one of two ways, chosen by a map-select input. The dense way keeps the low 16 address bits, so ports form one flat 64 KB space. The sparse way keeps the five lowest address bits and moves the 4 KB page number down beside them, so every 4 KB CPU page shows only 32 ports. This lets software give each small group of ports its own page for protection.

Accesses may be one, two or four bytes wide. When the CPU is big-endian, the bytes of halfword and word data are swapped in both directions so that multi-byte ports read with their natural value. A parameter turns this swapping on or off.

Top module: `isa_io_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, cpu_ack and io_req are 0.
- R2: A request whose address bits 31:23 differ from 9'h100 (outside 0x8000_0000..0x807F_FFFF) is never forwarded: io_req stays 0 and cpu_ack stays 0 for as long as it is held.
- R3: With map_mode = 0 at acceptance, io_addr equals cpu_addr[15:0] with bits 19:16 zero.
- R4: With map_mode = 1 at acceptance, io_addr[4:0] = cpu_addr[4:0] and io_addr[19:5] = cpu_addr[26:12].
- R5: map_mode is sampled in the cycle a request is accepted; changing it while the access is outstanding does not change io_addr.
- R6: io_req rises the cycle after an in-window request is seen while idle and stays high, with io_addr, io_size, io_we and io_wdata unchanged, until the cycle in which io_ack is sampled high.
- R7: cpu_ack is a one-cycle pulse in the cycle after io_ack is sampled; cpu_rdata at that point holds io_rdata as it was when io_ack was sampled, after lane handling.
- R8: Size code 2'b00 (byte): only byte lane 0 is carried, unreordered, in both directions; other lanes are zero.
- R9: Size code 2'b01 (halfword) with big-endian enabled: the two low bytes trade places in both directions and the upper 16 bits are zero.
- R10: Size codes 2'b10 and 2'b11 (word) with big-endian enabled: all four bytes are reversed in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_mode | input | 1 | 0 = dense 64 KB port space, 1 = sparse 32 ports per 4 KB page |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Completion pulse to the CPU |
| io_req | output | 1 | I/O access request, held until io_ack |
| io_we | output | 1 | I/O write enable |
| io_size | output | 2 | I/O access size, same code as cpu_size |
| io_addr | output | 20 | I/O port number |
| io_wdata | output | 32 | I/O write data after lane handling |
| io_rdata | input | 32 | I/O read data |
| io_ack | input | 1 | I/O completion |

## Verification
A wrong control state shows at once at the ports: a stuck or early io_req, or a cpu_ack that appears without io_ack or lasts two cycles, differs from the reference model in the very next cycle. A wrong captured address or data lane shows on io_addr or io_wdata in the first cycle of the request and on cpu_rdata in the acknowledge cycle. Because the model is compared on every clock, no fault can hide for longer than one access.

// File: rtl/isa_io_bridge_pkg.sv
// Shared types for the CPU-to-ISA I/O bridge.
// Assumes: size code 2'b11 is handled as a word access.
package isa_io_bridge_pkg;

    typedef enum logic [1:0] {
        XS_BYTE = 2'b00,
        XS_HALF = 2'b01,
        XS_WORD = 2'b10,
        XS_WIDE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DONE = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/isa_io_addr_map.sv
// Aperture decode and port-number translation.
// Dense mode keeps the low DENSE_W address bits. Sparse mode keeps PORT_BITS
// low bits and packs the page field PAGE_MSB:PAGE_LSB just above them.
// Assumes: IO_AW covers the sparse result; CPU_AW exceeds PAGE_MSB.
module isa_io_addr_map #(
    parameter int               CPU_AW   = 32,
    parameter int               IO_AW    = 20,
    parameter int               WIN_LOG2 = 23,
    parameter logic [CPU_AW-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              sparse,
    output logic              hit,
    output logic [IO_AW-1:0]  port
);
    localparam int DENSE_W   = 16;
    localparam int PORT_BITS = 5;
    localparam int PAGE_LSB  = 12;
    localparam int PAGE_MSB  = 26;
    localparam int SPARSE_W  = PAGE_MSB - PAGE_LSB + 1 + PORT_BITS;

    logic [IO_AW-1:0] dense_port;
    logic [IO_AW-1:0] sparse_port;

    // Aperture compare on the bits above the window size.
    assign hit = (cpu_addr[CPU_AW-1:WIN_LOG2] == WIN_BASE[CPU_AW-1:WIN_LOG2]);

    // Both candidate port numbers, zero-extended to the I/O width.
    assign dense_port  = {{(IO_AW-DENSE_W){1'b0}}, cpu_addr[DENSE_W-1:0]};
    assign sparse_port = {{(IO_AW-SPARSE_W){1'b0}},
                          cpu_addr[PAGE_MSB:PAGE_LSB], cpu_addr[PORT_BITS-1:0]};

    // Mode select.
    assign port = sparse ? sparse_port : dense_port;

endmodule

// File: rtl/isa_io_lane_swap.sv
// Byte-lane handling for one data direction.
// Byte: lane 0 only. Halfword: low two lanes, swapped when BIG_ENDIAN.
// Word: all lanes, reversed when BIG_ENDIAN. Unused lanes are zero.
// Assumes: DW is a multiple of 8 and at least 32.
module isa_io_lane_swap
    import isa_io_bridge_pkg::*;
#(
    parameter int DW         = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [1:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] half_v;
    logic [DW-1:0] word_v;

    generate
        if (BIG_ENDIAN) begin : g_swap
            // Swapped halfword and reversed word.
            always_comb begin
                half_v = '0;
                half_v[15:0] = {din[7:0], din[15:8]};
                for (int i = 0; i < LANES; i++) begin
                    word_v[8*i +: 8] = din[8*(LANES-1-i) +: 8];
                end
            end
        end else begin : g_straight
            // Lanes pass in order.
            always_comb begin
                half_v = '0;
                half_v[15:0] = din[15:0];
                word_v = din;
            end
        end
    endgenerate

    // Pick the lane arrangement by access size.
    always_comb begin
        dout = '0;
        case (size)
            XS_BYTE: dout[7:0] = din[7:0];
            XS_HALF: dout = half_v;
            default: dout = word_v;
        endcase
    end

endmodule

// File: rtl/isa_io_xfer_ctl.sv
// Handshake sequencer: idle -> wait for I/O completion -> acknowledge.
// Assumes: the CPU holds its request until ack and drops it in the ack cycle;
// the I/O side asserts io_ack only while io_req is high.
module isa_io_xfer_ctl
    import isa_io_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic io_ack,
    output logic load,
    output logic capture,
    output logic io_req,
    output logic ack
);
    ctl_state_e state;

    assign load    = (state == ST_IDLE) && start;
    assign capture = (state == ST_WAIT) && io_ack;
    assign io_req  = (state == ST_WAIT);
    assign ack     = (state == ST_DONE);

    // State advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start)  state <= ST_WAIT;
                ST_WAIT: if (io_ack) state <= ST_DONE;
                default:             state <= ST_IDLE;
            endcase
        end
    end

    // R6: request held until completion.
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> io_req);

    // R7: acknowledge only after a sampled completion.
    p_ack_after_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(io_req && io_ack));

    // R7: acknowledge lasts one cycle.
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R6: completion ends the request.
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_ack) |=> !io_req);

endmodule

// File: rtl/isa_io_bridge.sv
// CPU-to-ISA I/O bridge top. Decodes the aperture, translates the address
// with the mode sampled at acceptance, handles byte lanes and runs one
// I/O access per CPU access.
// Assumes: CPU inputs stay stable from request until cpu_ack.
module isa_io_bridge
    import isa_io_bridge_pkg::*;
#(
    parameter int                CPU_AW     = 32,
    parameter int                DW         = 32,
    parameter int                IO_AW      = 20,
    parameter int                WIN_LOG2   = 23,
    parameter logic [CPU_AW-1:0] WIN_BASE   = 32'h8000_0000,
    parameter bit                BIG_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ack,
    output logic              io_req,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [IO_AW-1:0]  io_addr,
    output logic [DW-1:0]     io_wdata,
    input  logic [DW-1:0]     io_rdata,
    input  logic              io_ack
);
    logic             hit;
    logic [IO_AW-1:0] port_nxt;
    logic [DW-1:0]    wdata_lanes;
    logic [DW-1:0]    rdata_lanes;
    logic             load;
    logic             capture;

    isa_io_addr_map #(
        .CPU_AW(CPU_AW), .IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
    ) u_map (
        .cpu_addr(cpu_addr), .sparse(map_mode), .hit(hit), .port(port_nxt)
    );

    isa_io_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_wlanes (
        .size(cpu_size), .din(cpu_wdata), .dout(wdata_lanes)
    );

    isa_io_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_rlanes (
        .size(io_size), .din(io_rdata), .dout(rdata_lanes)
    );

    isa_io_xfer_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .start(cpu_req && hit), .io_ack(io_ack),
        .load(load), .capture(capture), .io_req(io_req), .ack(cpu_ack)
    );

    // Latch the translated access at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_addr  <= '0;
            io_size  <= XS_BYTE;
            io_we    <= 1'b0;
            io_wdata <= '0;
        end else if (load) begin
            io_addr  <= port_nxt;
            io_size  <= cpu_size;
            io_we    <= cpu_we;
            io_wdata <= wdata_lanes;
        end
    end

    // Capture read data when the I/O side completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (capture) begin
            cpu_rdata <= rdata_lanes;
        end
    end

    // R2: an out-of-aperture request seen while idle is not forwarded.
    p_no_fwd_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !hit && !io_req && !cpu_ack) |=> !io_req);

    // R5: port number held while the request is outstanding.
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> $stable(io_addr));

    // R6: write data and size held while outstanding.
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> ($stable(io_wdata) && $stable(io_size) && $stable(io_we)));

endmodule

// File: tb/isa_io_bridge_test.sv
module isa_io_bridge_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b00;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        io_req;
    logic        io_we;
    logic [1:0]  io_size;
    logic [19:0] io_addr;
    logic [31:0] io_wdata;
    logic [31:0] io_rdata = '0;
    logic        io_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int dev_lat = 0;
    int dev_wait = 0;
    logic [31:0] dev_data = '0;

    // reference model state
    bit          m_busy = 0;
    bit          m_done = 0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  m_size = '0;
    bit          m_we = 0;
    bit          m_mode = 0;
    bit          in_reset_cycle = 1;

    isa_io_bridge uut (
        .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .io_req(io_req), .io_we(io_we), .io_size(io_size), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_port(logic [31:0] a, bit sparse);
        if (!sparse) return a & 32'h0000_FFFF;
        return (a & 32'h1F) | ((a & 32'h07FF_F000) >> 7);
    endfunction

    function automatic logic [31:0] exp_lanes(logic [31:0] d, logic [1:0] sz);
        logic [31:0] r;
        r = 0;
        if (sz == 2'b00) r = d & 32'hFF;
        else if (sz == 2'b01) r = ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
        else for (int k = 0; k < 4; k++) r[8*(3-k) +: 8] = d[8*k +: 8];
        return r;
    endfunction

    function automatic bit in_window(logic [31:0] a);
        return (a >= 32'h8000_0000) && (a < 32'h8080_0000);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model advance
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; in_reset_cycle <= 1;
        end else begin
            in_reset_cycle <= 0;
            if (m_done) m_done <= 0;
            else if (m_busy) begin
                if (io_ack) begin
                    m_busy <= 0; m_done <= 1;
                    m_rdata <= exp_lanes(io_rdata, m_size);
                end
            end else if (cpu_req && in_window(cpu_addr)) begin
                m_busy <= 1;
                m_mode <= map_mode;
                m_addr <= exp_port(cpu_addr, map_mode);
                m_wdata <= exp_lanes(cpu_wdata, cpu_size);
                m_size <= cpu_size;
                m_we <= cpu_we;
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n || in_reset_cycle) begin
            chk(!cpu_ack && !io_req, "R1 reset outputs", {30'b0, cpu_ack, io_req}, 0);
        end else begin
            chk(io_req == m_busy, "R6 io_req", io_req, m_busy);
            chk(cpu_ack == m_done, "R7 cpu_ack", cpu_ack, m_done);
            if (m_busy) begin
                chk(io_addr == m_addr[19:0], m_mode ? "R4 sparse io_addr" : "R3 dense io_addr",
                    io_addr, m_addr);
                chk(io_wdata == m_wdata,
                    m_size == 0 ? "R8 byte io_wdata" : (m_size == 1 ? "R9 half io_wdata" : "R10 word io_wdata"),
                    io_wdata, m_wdata);
                chk(io_size == m_size && io_we == m_we, "R6 io_size/io_we",
                    {29'b0, io_we, io_size}, {29'b0, m_we, m_size});
            end
            if (m_done)
                chk(cpu_rdata == m_rdata,
                    m_size == 0 ? "R8 byte rdata" : (m_size == 1 ? "R9 half rdata" : "R10 word rdata"),
                    cpu_rdata, m_rdata);
        end
    end

    // simple I/O device with programmable latency
    always @(negedge clk) begin
        if (io_req && !io_ack) begin
            if (dev_wait >= dev_lat) begin
                io_ack = 1; io_rdata = dev_data; dev_wait = 0;
            end else dev_wait++;
        end else begin
            io_ack = 0;
        end
    end

    // one CPU access; optionally flips map_mode while outstanding
    task automatic xfer(logic [31:0] a, logic [1:0] sz, bit we, logic [31:0] wd,
                        bit mode, int lat, logic [31:0] rd, bit flip);
        int n;
        @(negedge clk);
        dev_lat = lat; dev_data = rd;
        map_mode = mode; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
        cpu_req = 1;
        n = 0;
        do begin
            @(negedge clk);
            if (flip) map_mode = ~mode;
            n++;
        end while (!cpu_ack && n < 30);
        chk(cpu_ack, "R7 access completes", {31'b0, cpu_ack}, 1);
        cpu_req = 0;
        map_mode = mode;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        xfer(32'h8000_1234, 2'b00, 1, 32'hAABB_CC5A, 0, 0, 0, 0);          // R3 R8
        xfer(32'h8000_03F8, 2'b00, 0, 0, 0, 2, 32'h1122_3344, 0);           // R8 read
        xfer(32'h8012_3A17, 2'b01, 1, 32'hDEAD_BEEF, 1, 1, 0, 0);           // R4 R9
        xfer(32'h8000_0062, 2'b01, 0, 0, 0, 0, 32'h5566_7788, 0);           // R9 read
        xfer(32'h807F_F01F, 2'b10, 1, 32'h0102_0304, 1, 3, 0, 0);           // R4 R10
        xfer(32'h8000_FFFC, 2'b10, 0, 0, 0, 1, 32'hCAFE_F00D, 0);           // R3 R10
        xfer(32'h8040_5008, 2'b11, 0, 0, 1, 0, 32'h89AB_CDEF, 0);           // R10 wide code
        xfer(32'h8003_4005, 2'b10, 1, 32'h7777_1111, 1, 4, 0, 1);           // R5 flip sparse
        xfer(32'h8003_4005, 2'b00, 1, 32'h0000_0099, 0, 4, 0, 1);           // R5 flip dense

        // R2: outside the aperture (just below and just above)
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            cpu_addr = (t == 0) ? 32'h7FFF_FFFC : 32'h8080_0000;
            cpu_size = 2'b10; cpu_we = 1; cpu_req = 1;
            repeat (5) begin
                @(negedge clk);
                chk(!io_req && !cpu_ack, "R2 outside not forwarded",
                    {30'b0, io_req, cpu_ack}, 0);
            end
            cpu_req = 0;
        end

        xfer(32'h8000_0001, 2'b01, 0, 0, 0, 0, 32'h0000_A1B2, 0);           // after R2
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule